// File: doc/BRIEF.md
# Wrap-to-One Interval Timer

The block is an interval timer for a large chip. A host reaches it through a small word-addressed register port. A tick enable input, one pulse per time step, drives the count. In normal mode the counter climbs toward a programmed limit. When the next value would equal the limit, the counter returns to 1 instead and sets a sticky limit-reached flag. That flag drives a level interrupt request. Because the count restarts at 1, dividing the tick by N takes a limit of N+1.

Software clears the flag by reading the limit register. A second, side-effect-free view of the limit returns the same word without clearing anything. A user mode turns the counter into a free-running counter with no limit. In that mode it advances only while a run bit is set.

Both count words carry the flag in bit 31 and the count in a field below it. With the default step of 1 us the field is 21 bits wide at bits 30:10. When the parameter `HALF_US_STEP` is set, the field is 22 bits wide at bits 30:9 and the step is 500 ns.

Top module: `itmr_top`

## Requirements
- R1: After reset, the counter reads count 1, the limit reads 0, the flag and `irq_o` are 0, and the run and mode registers read 0.
- R2: A write to the limit register (address 1) stores the count field of `wdata_i`, sets the counter to 1 and clears the flag. In that same cycle it takes priority over a tick.
- R3: In normal mode, each tick raises the count by one, unless the raised value equals the limit. In that case the count becomes 1 and the flag is set. A limit of 4 gives 1,2,3,1, and a limit of N+1 divides the tick by N.
- R4: The counter (address 0), limit (address 1) and limit view (address 2) read the flag in bit 31 and the count field at bits 30:10 by default. All bits below the field read 0, and written bits outside the field are not stored.
- R5: Without a tick, the counter holds its value.
- R6: A read of the limit register clears the flag, and `irq_o` is low from the next cycle. If the same cycle's tick reaches the limit, the flag stays set.
- R7: A read of the limit view (address 2) returns the limit word and leaves the flag unchanged.
- R8: `irq_o` equals the flag. It stays high until a limit read or a limit write clears it.
- R9: When the mode register (address 4) bit 0 is 1, the counter advances on a tick only while the run register (address 3) bit 0 is 1. It counts past the limit and never sets the flag.
- R10: The run and mode registers store and read back only bit 0, with the other bits reading 0. Writes to the counter address and to unused addresses 5 to 7 have no effect, and unused addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | One-step count enable |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe (limit read clears the flag) |
| addr_i | input | 3 | Register word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i`, combinational |
| irq_o | output | 1 | Level interrupt request, equal to the flag |

## Verification
On every cycle, the assertions check several properties. A limit write restarts the count at 1 with the flag clear, and the count holds without a tick or while stopped in user mode. The flag never rises in user mode, the interrupt is sticky until cleared, and the bits below the field always read zero. Other behaviours appear only in the bench's scenarios against its reference model: the exact wrap sequence for several limits, the set-over-clear race on a limit read, the side-effect-free limit view, and the ignored writes to the counter and unused addresses.

// File: rtl/itmr_pkg.sv
package itmr_pkg;
    localparam int unsigned ADDR_W  = 3;
    localparam int unsigned WORD_W  = 32;
    localparam logic [ADDR_W-1:0] ADR_COUNT = 3'd0;
    localparam logic [ADDR_W-1:0] ADR_LIMIT = 3'd1;
    localparam logic [ADDR_W-1:0] ADR_PEEK  = 3'd2;
    localparam logic [ADDR_W-1:0] ADR_RUN   = 3'd3;
    localparam logic [ADDR_W-1:0] ADR_MODE  = 3'd4;
endpackage

// File: rtl/itmr_regs.sv
module itmr_regs
    import itmr_pkg::*;
#(
    parameter int unsigned CNT_W     = 21,
    parameter int unsigned FIELD_LSB = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [WORD_W-1:0] wdata_i,
    output logic [CNT_W-1:0]  limit_o,
    output logic              run_o,
    output logic              user_o,
    output logic              restart_o
);
    typedef struct packed {
        logic [CNT_W-1:0] lim;
        logic             run;
        logic             user;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d       = r_q;
        restart_o = 1'b0;
        if (wr_en_i) begin
            case (addr_i)
                ADR_LIMIT: begin
                    r_d.lim   = wdata_i[FIELD_LSB +: CNT_W];
                    restart_o = 1'b1;
                end
                ADR_RUN:  r_d.run  = wdata_i[0];
                ADR_MODE: r_d.user = wdata_i[0];
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign limit_o = r_q.lim;
    assign run_o   = r_q.run;
    assign user_o  = r_q.user;

    // R10: run bit only changes through its own register write
    a_r10_run_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en_i && addr_i == ADR_RUN) |=> $stable(run_o));
    // R10: mode bit only changes through its own register write
    a_r10_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en_i && addr_i == ADR_MODE) |=> $stable(user_o));
endmodule

// File: rtl/itmr_counter.sv
module itmr_counter #(
    parameter int unsigned CNT_W = 21
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             restart_i,
    input  logic             clear_i,
    input  logic             user_i,
    input  logic             run_i,
    input  logic [CNT_W-1:0] limit_i,
    output logic [CNT_W-1:0] count_o,
    output logic             flag_o
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             flag;
    } cnt_t;

    cnt_t c_d, c_q;
    logic [CNT_W-1:0] inc;
    logic             step, hit;

    always_comb begin
        inc  = c_q.cnt + ONE;
        step = tick_i && (!user_i || run_i);
        hit  = tick_i && !user_i && (inc == limit_i);
        c_d  = c_q;
        if (restart_i) begin
            c_d.cnt  = ONE;
            c_d.flag = 1'b0;
        end else begin
            if (step) c_d.cnt = hit ? ONE : inc;
            if (hit)          c_d.flag = 1'b1;
            else if (clear_i) c_d.flag = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_q.cnt  <= ONE;
            c_q.flag <= 1'b0;
        end else begin
            c_q <= c_d;
        end
    end

    assign count_o = c_q.cnt;
    assign flag_o  = c_q.flag;

    // R2: a limit write leaves count 1 and the flag clear
    a_r2_restart: assert property (@(posedge clk) disable iff (!rst_n)
        restart_i |=> (count_o == ONE) && !flag_o);
    // R5: no tick and no restart keeps the count
    a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !restart_i) |=> $stable(count_o));
    // R9: stopped user mode keeps the count
    a_r9_stopped: assert property (@(posedge clk) disable iff (!rst_n)
        (user_i && !run_i && !restart_i) |=> $stable(count_o));
    // R9: the flag never rises from a user-mode cycle
    a_r9_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
        user_i |=> !$rose(flag_o));
endmodule

// File: rtl/itmr_top.sv
module itmr_top
    import itmr_pkg::*;
#(
    parameter bit HALF_US_STEP = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              wr_en_i,
    input  logic              rd_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [WORD_W-1:0] wdata_i,
    output logic [WORD_W-1:0] rdata_o,
    output logic              irq_o
);
    localparam int unsigned CNT_W     = HALF_US_STEP ? 22 : 21;
    localparam int unsigned FIELD_LSB = (WORD_W - 1) - CNT_W;

    logic [CNT_W-1:0] limit_w, count_w;
    logic             run_w, user_w, restart_w, flag_w, clear_w;

    assign clear_w = rd_en_i && (addr_i == ADR_LIMIT);

    itmr_regs #(.CNT_W(CNT_W), .FIELD_LSB(FIELD_LSB)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en_i),
        .addr_i    (addr_i),
        .wdata_i   (wdata_i),
        .limit_o   (limit_w),
        .run_o     (run_w),
        .user_o    (user_w),
        .restart_o (restart_w)
    );

    itmr_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (tick_i),
        .restart_i (restart_w),
        .clear_i   (clear_w),
        .user_i    (user_w),
        .run_i     (run_w),
        .limit_i   (limit_w),
        .count_o   (count_w),
        .flag_o    (flag_w)
    );

    always_comb begin
        rdata_o = '0;
        case (addr_i)
            ADR_COUNT: begin
                rdata_o[WORD_W-1]            = flag_w;
                rdata_o[FIELD_LSB +: CNT_W]  = count_w;
            end
            ADR_LIMIT, ADR_PEEK: begin
                rdata_o[WORD_W-1]            = flag_w;
                rdata_o[FIELD_LSB +: CNT_W]  = limit_w;
            end
            ADR_RUN:  rdata_o[0] = run_w;
            ADR_MODE: rdata_o[0] = user_w;
            default:  rdata_o = '0;
        endcase
    end

    assign irq_o = flag_w;

    // R4: bits below the count field always read zero on count words
    a_r4_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_i <= ADR_PEEK) |-> (rdata_o[FIELD_LSB-1:0] == '0));
    // R8: the request stays high unless a limit read or write clears it
    a_r8_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !clear_w && !restart_w) |=> irq_o);
    // R6: a limit read with no tick drops the request next cycle
    a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (clear_w && !tick_i) |=> !irq_o);
endmodule

// File: tb/tb_itmr_top.sv
module tb_itmr_top;
    localparam int LSB  = 10;
    localparam int MAXV = 1 << 21;
    localparam int MASK = MAXV - 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0, wr = 1'b0, rd = 1'b0;
    logic [2:0]  addr = 3'd0;
    logic [31:0] wd = '0;
    logic [31:0] rdata;
    logic        irq;

    int checks = 0, errors = 0;
    int m_cnt, m_lim, m_flag, m_run, m_user;

    always #4 clk = ~clk;

    itmr_top dut (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .wr_en_i(wr), .rd_en_i(rd),
        .addr_i(addr), .wdata_i(wd), .rdata_o(rdata), .irq_o(irq)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] model_word(int a);
        logic [31:0] w = '0;
        case (a)
            0: w = (32'(m_flag) << 31) | (32'(m_cnt) << LSB);
            1, 2: w = (32'(m_flag) << 31) | (32'(m_lim) << LSB);
            3: w = 32'(m_run);
            4: w = 32'(m_user);
            default: w = '0;
        endcase
        return w;
    endfunction

    task automatic model_step(bit t, bit w, bit r, int a, logic [31:0] d);
        int n;
        bit hit = 0;
        if (w && a == 1) begin
            m_cnt = 1; m_flag = 0; m_lim = int'(d >> LSB) & MASK;
        end else begin
            if (t && m_user != 0 && m_run != 0) m_cnt = (m_cnt + 1) % MAXV;
            else if (t && m_user == 0) begin
                n = (m_cnt + 1) % MAXV;
                if (n == m_lim) begin m_cnt = 1; hit = 1; end
                else m_cnt = n;
            end
            if (hit) m_flag = 1;
            else if (r && a == 1) m_flag = 0;
        end
        if (w && a == 3) m_run  = int'(d[0]);
        if (w && a == 4) m_user = int'(d[0]);
    endtask

    // one clock: compare irq, drive, compare read data, update model at the edge
    task automatic cyc(string req, bit t, bit w, bit r, int a, logic [31:0] d);
        @(negedge clk);
        check({req, "/R8 irq"}, 32'(irq), 32'(m_flag));
        tick = t; wr = w; rd = r; addr = 3'(a); wd = d;
        #1;
        check(req, rdata, model_word(a));
        @(posedge clk);
        model_step(t, w, r, a, d);
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        m_cnt = 1; m_lim = 0; m_flag = 0; m_run = 0; m_user = 0;
        repeat (4) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1 reset state of every register, R10 unused address reads zero
        for (int a = 0; a < 5; a++) cyc("R1", 0, 0, 0, a, 0);
        cyc("R10", 0, 0, 0, 6, 0);

        // R2 limit write, then R3 sequence 1,2,3,1 with limit 4
        cyc("R2", 0, 1, 0, 1, 32'(4) << LSB);
        for (int i = 0; i < 7; i++) cyc("R3", 1, 0, 0, 0, 0);
        // R5 hold without ticks
        for (int i = 0; i < 4; i++) cyc("R5", 0, 0, 0, 0, 0);
        // R7 view read keeps the flag
        cyc("R7", 0, 0, 1, 2, 0);
        cyc("R7", 0, 0, 0, 2, 0);
        // R6 limit read clears the flag
        cyc("R6", 0, 0, 1, 1, 0);
        cyc("R6", 0, 0, 0, 0, 0);
        // R6 set wins over clear: bring count to 3 then tick with a limit read
        while (m_cnt != 3) cyc("R3", 1, 0, 0, 0, 0);
        cyc("R6", 1, 0, 1, 1, 0);
        cyc("R6", 0, 0, 0, 1, 0);

        // R4 bits outside the field are dropped; limit 2 wraps every tick
        cyc("R4", 0, 1, 0, 1, 32'h8000_03FF | (32'(2) << LSB));
        cyc("R4", 0, 0, 0, 1, 0);
        for (int i = 0; i < 4; i++) cyc("R3", 1, 0, 0, 0, 0);

        // R2 write during a tick restarts mid-count
        cyc("R2", 0, 1, 0, 1, 32'(10) << LSB);
        for (int i = 0; i < 4; i++) cyc("R3", 1, 0, 0, 0, 0);
        cyc("R2", 1, 1, 0, 1, 32'(6) << LSB);
        cyc("R2", 0, 0, 0, 0, 0);
        // R3 divide by five with limit 6, clearing the flag after each period
        for (int i = 0; i < 20; i++) cyc("R3", 1, 0, (i % 5) == 4, (i % 5) == 4 ? 1 : 0, 0);

        // R10 ignored writes and one-bit registers
        cyc("R10", 0, 1, 0, 0, 32'hFFFF_FFFF);
        cyc("R10", 0, 0, 0, 0, 0);
        cyc("R10", 0, 1, 0, 6, 32'hFFFF_FFFF);
        cyc("R10", 0, 0, 0, 6, 0);
        cyc("R10", 0, 1, 0, 3, 32'hFFFF_FFFE);
        cyc("R10", 0, 0, 0, 3, 0);

        // R9 user mode: stopped holds, running passes the limit without a flag
        cyc("R9", 0, 1, 0, 1, 32'(3) << LSB);
        cyc("R9", 0, 1, 0, 4, 32'h1);
        for (int i = 0; i < 3; i++) cyc("R9", 1, 0, 0, 0, 0);
        cyc("R9", 0, 1, 0, 3, 32'h1);
        for (int i = 0; i < 6; i++) cyc("R9", 1, 0, 0, 0, 0);
        cyc("R9", 0, 1, 0, 3, 32'h0);
        for (int i = 0; i < 3; i++) cyc("R9", 1, 0, 0, 0, 0);
        cyc("R9", 0, 0, 0, 4, 0);
        cyc("R9", 0, 1, 0, 4, 32'h0);
        cyc("R2", 0, 1, 0, 1, 32'(3) << LSB);
        for (int i = 0; i < 3; i++) cyc("R3", 1, 0, 0, 0, 0);
        cyc("R8", 0, 0, 0, 0, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule